// File: doc/BRIEF.md
# Four-Instruction Load-Store Execution Core

This block is a single-cycle execution core for a small 32-bit load-store instruction set. Each clock cycle it fetches one instruction word from an instruction port, decodes it, reads up to two source registers from a 32-entry register file, forms a result or an address in one shared adder/subtractor, and commits the outcome on the next rising clock edge. Four operations are recognised: register add, register subtract, word load and word store. Every other encoding retires as a no-op.

Both memories are combinational from the core's point of view. The instruction word has to be valid while the fetch address is stable, and read data has to come back within the same cycle that the read strobe is high. The program counter steps by four on every cycle after reset, because there is no control flow. Register 0 is a constant zero. The core has no pipeline, so one instruction completes per cycle.

The single decode stage sorts each word into one of five operation classes, an enumerated type: `OPC_ADD`, `OPC_SUB`, `OPC_LOAD`, `OPC_STORE` and `OPC_NOP`. The class is a pure function of the current word and carries no state from one cycle to the next. The only sequential state is the program counter and the register file, and both are cleared by a synchronous active-low reset.

Top module: `lsc_core`

## Requirements
- R1: During reset the fetch address is 0. After reset is released, the fetch address rises by exactly 4 on every clock edge.
- R2: Register 0 always reads as zero. A write aimed at register 0 is dropped, and a later store of register 0 puts 0 on the write-data port.
- R3: Opcode 0 (bits 31:26) with function code 32 (bits 5:0) writes rs + rt into rd. The fields are rs in bits 25:21, rt in bits 20:16 and rd in bits 15:11.
- R4: Opcode 0 with function code 34 writes rs - rt into rd.
- R5: Opcode 35 raises the read strobe with the address set to rs plus the offset. The returned read data is written into rt at the next edge.
- R6: Opcode 43 raises the write strobe with the address set to rs plus the offset and the write data set to the value of rt. No strobe is raised while reset is asserted.
- R7: The load/store offset is bits 15:0, sign-extended to 32 bits before it is added to the base register.
- R8: Add and subtract wrap modulo 2^32 and have no overflow side effect.
- R9: Any other opcode, or opcode 0 with any function code other than 32 or 34, changes no register and raises neither memory strobe. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Instruction fetch byte address (the program counter) |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Data byte address for a load or store |
| dmem_wdata | output | 32 | Store data, the value of rt |
| dmem_rdata | input | 32 | Load data at dmem_addr, valid in the same cycle |
| dmem_we | output | 1 | Data write strobe, high for a store |
| dmem_re | output | 1 | Data read strobe, high for a load |

## Verification
The assertions assume that the instruction word and the load data are settled before the sampling edge, which means both memories answer combinationally from the current addresses. They also assume that reset is held for at least one edge, so the program counter and the registers start from known values. The bench models both memories as zero-latency arrays indexed by address bits, writes its data array only on edges where the store strobe is high, and changes its inputs only on falling edges. It sweeps operand and destination indices over every register, walks offsets across the sign boundary, and includes unrecognised encodings. Every register value is brought out through stores and compared against an arithmetic model kept in the bench.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned RIDX_W  = 5;
    localparam int unsigned OFF_W   = 16;

    localparam logic [5:0] OPCODE_REG   = 6'd0;
    localparam logic [5:0] OPCODE_LOAD  = 6'd35;
    localparam logic [5:0] OPCODE_STORE = 6'd43;
    localparam logic [5:0] FUNCT_ADD    = 6'd32;
    localparam logic [5:0] FUNCT_SUB    = 6'd34;

    typedef enum logic [2:0] {
        OPC_NOP   = 3'd0,
        OPC_ADD   = 3'd1,
        OPC_SUB   = 3'd2,
        OPC_LOAD  = 3'd3,
        OPC_STORE = 3'd4
    } op_class_e;

    typedef struct packed {
        op_class_e cls;
        logic      reg_we;
        logic      dst_is_rt;
        logic      wb_mem;
        logic      mem_we;
        logic      mem_re;
        logic      alu_sub;
        logic      use_imm;
    } ctrl_t;

endpackage

// File: rtl/lsc_pc.sv
module lsc_pc #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    logic [XLEN-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_q + STEP_V;
    end

    assign pc_o = pc_q;

    // R1
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (pc_q == $past(pc_q) + STEP_V));

    // R1
    pc_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0));

endmodule

// File: rtl/lsc_decode.sv
module lsc_decode
    import lsc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [RIDX_W-1:0]  rs_idx,
    output logic [RIDX_W-1:0]  rt_idx,
    output logic [RIDX_W-1:0]  rd_idx,
    output logic [XLEN-1:0]    imm_ext
);
    logic [5:0]       opcode;
    logic [5:0]       funct;
    logic [OFF_W-1:0] off;

    assign opcode  = instr[31:26];
    assign funct   = instr[5:0];
    assign off     = instr[15:0];
    assign rs_idx  = instr[25:21];
    assign rt_idx  = instr[20:16];
    assign rd_idx  = instr[15:11];
    assign imm_ext = {{(XLEN-OFF_W){off[OFF_W-1]}}, off};

    op_class_e cls;

    always_comb begin
        cls = OPC_NOP;
        unique case (opcode)
            OPCODE_REG: begin
                unique case (funct)
                    FUNCT_ADD: cls = OPC_ADD;
                    FUNCT_SUB: cls = OPC_SUB;
                    default:   cls = OPC_NOP;
                endcase
            end
            OPCODE_LOAD:  cls = OPC_LOAD;
            OPCODE_STORE: cls = OPC_STORE;
            default:      cls = OPC_NOP;
        endcase
    end

    always_comb begin
        ctrl     = '0;
        ctrl.cls = cls;
        unique case (cls)
            OPC_ADD: begin
                ctrl.reg_we = 1'b1;
            end
            OPC_SUB: begin
                ctrl.reg_we  = 1'b1;
                ctrl.alu_sub = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_we    = 1'b1;
                ctrl.dst_is_rt = 1'b1;
                ctrl.wb_mem    = 1'b1;
                ctrl.mem_re    = 1'b1;
                ctrl.use_imm   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
            end
            default: begin
                ctrl.reg_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lsc_regfile.sv
module lsc_regfile #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rdata_a,
    output logic [XLEN-1:0] rdata_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rdata_a = regs[ra_a];
    assign rdata_b = regs[ra_b];

    // R2
    zero_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == '0) |-> (rdata_a == '0));

    // R2
    zero_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_b == '0) |-> (rdata_b == '0));

    // R3
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/lsc_addsub.sv
module lsc_addsub #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            sub,
    output logic [XLEN-1:0] y
);
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] cin;

    assign b_eff = sub ? ~b : b;
    assign cin   = {{(XLEN-1){1'b0}}, sub};
    assign y     = a + b_eff + cin;

endmodule

// File: rtl/lsc_core.sv
module lsc_core
    import lsc_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned NREG    = 32,
    parameter int unsigned PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [XLEN-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_rdata,
    output logic [XLEN-1:0]    dmem_addr,
    output logic [XLEN-1:0]    dmem_wdata,
    input  logic [XLEN-1:0]    dmem_rdata,
    output logic               dmem_we,
    output logic               dmem_re
);
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic [XLEN-1:0]   wb_data;
    logic [RIDX_W-1:0] wb_idx;
    logic              wb_en;

    lsc_pc #(.XLEN(XLEN), .STEP(PC_STEP)) u_pc (
        .clk  (clk),
        .rst_n(rst_n),
        .pc_o (imem_addr)
    );

    lsc_decode #(.XLEN(XLEN)) u_dec (
        .instr  (imem_rdata),
        .ctrl   (ctrl),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .imm_ext(imm_ext)
    );

    lsc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_a   (rs_idx),
        .ra_b   (rt_idx),
        .rdata_a(rs_val),
        .rdata_b(rt_val),
        .we     (wb_en),
        .wa     (wb_idx),
        .wd     (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

    lsc_addsub #(.XLEN(XLEN)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .sub(ctrl.alu_sub),
        .y  (alu_y)
    );

    always_comb begin
        wb_en   = rst_n & ctrl.reg_we;
        wb_idx  = ctrl.dst_is_rt ? rt_idx : rd_idx;
        wb_data = ctrl.wb_mem ? dmem_rdata : alu_y;
    end

    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = rst_n & ctrl.mem_we;
    assign dmem_re    = rst_n & ctrl.mem_re;

    // R6
    store_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> ((imem_rdata[31:26] == OPCODE_STORE) && (dmem_wdata == rt_val)));

    // R5
    load_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_re |-> (imem_rdata[31:26] == OPCODE_LOAD));

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_we, dmem_re}));

    // R7
    ea_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we || dmem_re) |->
        ((dmem_addr - rs_val) == {{(XLEN-OFF_W){imem_rdata[15]}}, imem_rdata[15:0]}));

    // R4
    sub_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cls == OPC_SUB) |-> ((alu_y + rt_val) == rs_val));

    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.cls == OPC_NOP) |-> (!wb_en && !dmem_we && !dmem_re));

endmodule

// File: tb/tb_lsc_core.sv
`timescale 1ns/1ps
module tb_lsc_core;

    localparam int PROG_N = 512;
    localparam int DMEM_N = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re;

    always #10 clk = ~clk;

    lsc_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_rdata(imem_rdata),
        .dmem_addr (dmem_addr),
        .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata),
        .dmem_we   (dmem_we),
        .dmem_re   (dmem_re)
    );

    logic [31:0] prog [PROG_N];
    logic [31:0] dmem [DMEM_N];
    logic [31:0] mreg [32];
    logic [31:0] mmem [DMEM_N];
    logic        exp_st [PROG_N];
    logic        exp_ld [PROG_N];
    logic [31:0] exp_addr [PROG_N];
    logic [31:0] exp_data [PROG_N];
    string       exp_tag [PROG_N];
    int          pc_n = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    int          st_i = 0;

    assign imem_rdata = prog[imem_addr[10:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] o);
        return {{16{o[15]}}, o};
    endfunction

    task automatic put(input logic [31:0] w, input bit st, input bit ld,
                       input logic [31:0] a, input logic [31:0] d, input string tag);
        prog[pc_n]     = w;
        exp_st[pc_n]   = st;
        exp_ld[pc_n]   = ld;
        exp_addr[pc_n] = a;
        exp_data[pc_n] = d;
        exp_tag[pc_n]  = tag;
        pc_n++;
    endtask

    task automatic g_arith(input bit is_sub, input int rd, input int rs, input int rt, input string tag);
        logic [31:0] r;
        r = is_sub ? mreg[rs] - mreg[rt] : mreg[rs] + mreg[rt];
        if (rd != 0) mreg[rd] = r;
        put({6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, is_sub ? 6'd34 : 6'd32}, 0, 0, 0, 0, tag);
    endtask

    task automatic g_lw(input int rt, input int rs, input logic [15:0] off, input string tag);
        logic [31:0] ea;
        ea = mreg[rs] + sx(off);
        if (rt != 0) mreg[rt] = mmem[ea[9:2]];
        put({6'd35, 5'(rs), 5'(rt), off}, 0, 1, ea, 0, tag);
    endtask

    task automatic g_sw(input int rt, input int rs, input logic [15:0] off, input string tag);
        logic [31:0] ea;
        ea = mreg[rs] + sx(off);
        mmem[ea[9:2]] = mreg[rt];
        put({6'd43, 5'(rs), 5'(rt), off}, 1, 0, ea, mreg[rt], tag);
    endtask

    task automatic g_dump(input int rt, input string tag);
        g_sw(rt, 0, 16'(16'h0300 + (st_i % 64) * 4), tag);
        st_i++;
    endtask

    task automatic build;
        for (int i = 0; i < PROG_N; i++) put_blank(i);
        for (int i = 0; i < 32; i++) mreg[i] = '0;
        for (int i = 0; i < DMEM_N; i++) mmem[i] = i * 32'h9E37_79B9 + 32'h0123_4567;
        mmem[1] = 32'hFFFF_FFFF;
        mmem[2] = 32'h0000_0001;
        mmem[3] = 32'h8000_0000;
        for (int i = 0; i < DMEM_N; i++) dmem[i] = mmem[i];
        // R5: load every register
        for (int r = 1; r < 32; r++) g_lw(r, 0, 16'(r * 4), "R5");
        // R8: wrap-around cases
        g_arith(0, 4, 1, 2, "R8"); g_dump(4, "R8");
        g_arith(1, 5, 0, 2, "R8"); g_dump(5, "R8");
        g_arith(0, 6, 3, 3, "R8"); g_dump(6, "R8");
        g_arith(1, 7, 3, 2, "R8"); g_dump(7, "R8");
        // R3 / R4: sweep destinations and operand pairs
        for (int i = 0; i < 96; i++) begin
            int d, s, t;
            d = i % 32; s = (i * 7 + 3) % 32; t = (i * 13 + 5) % 32;
            g_arith(i[0], d, s, t, i[0] ? "R4" : "R3");
            g_dump(d, d == 0 ? "R2" : (i[0] ? "R4" : "R3"));
        end
        // R2: register 0 stays zero after writes
        g_arith(0, 0, 1, 3, "R2"); g_dump(0, "R2");
        g_lw(0, 0, 16'h0008, "R2"); g_dump(0, "R2");
        // R7: offsets across the sign boundary with a nonzero base
        foreach (offs_list[k]) begin
            g_sw(9, 10, offs_list[k], "R7");
            g_lw(11, 10, offs_list[k], "R7");
            g_dump(11, "R5");
        end
        // R9: unrecognised encodings
        put({6'd8, 5'd1, 5'd3, 16'h0010}, 0, 0, 0, 0, "R9");
        put({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd33}, 0, 0, 0, 0, "R9");
        put({6'd36, 5'd0, 5'd3, 16'h0004}, 0, 0, 0, 0, "R9");
        put({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd0}, 0, 0, 0, 0, "R9");
        put({6'd2, 26'h3FF_FFFF}, 0, 0, 0, 0, "R9");
        g_dump(3, "R9");
        g_dump(1, "R9");
    endtask

    logic [15:0] offs_list [4] = '{16'h7FFC, 16'h8000, 16'hFFFC, 16'h0004};

    task automatic put_blank(input int i);
        prog[i] = 32'h0; exp_st[i] = 0; exp_ld[i] = 0;
        exp_addr[i] = 0; exp_data[i] = 0; exp_tag[i] = "R2";
    endtask

    initial begin
        build();
        repeat (3) begin
            @(negedge clk);
            // R1 / R6: reset state
            chk(imem_addr == 32'h0, "R1", imem_addr, 32'h0);
            chk(!dmem_we && !dmem_re, "R6", {30'd0, dmem_we, dmem_re}, 32'h0);
        end
        rst_n = 1'b1;
        for (int k = 0; k < pc_n + 4; k++) begin
            #1;
            chk(imem_addr == 32'(k * 4), "R1", imem_addr, 32'(k * 4));
            if (exp_st[k]) begin
                chk(dmem_we && !dmem_re, exp_tag[k], {30'd0, dmem_we, dmem_re}, 32'h2);
                chk(dmem_addr == exp_addr[k], exp_tag[k], dmem_addr, exp_addr[k]);
                chk(dmem_wdata == exp_data[k], exp_tag[k], dmem_wdata, exp_data[k]);
            end else if (exp_ld[k]) begin
                chk(dmem_re && !dmem_we, "R5", {30'd0, dmem_we, dmem_re}, 32'h1);
                chk(dmem_addr == exp_addr[k], exp_tag[k], dmem_addr, exp_addr[k]);
            end else begin
                chk(!dmem_we && !dmem_re, exp_tag[k], {30'd0, dmem_we, dmem_re}, 32'h0);
            end
            @(negedge clk);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule